// File: doc/BRIEF.md
# SPI Transfer Request Validator

This block decides whether a single SPI transfer request can be run by a controller with a given set of capabilities. The request fields and the capability set are presented in parallel. The request fields are chip-select index, word width, chip-select toggle flag, transmit and receive lane counts, mode word, clock rate, four timing delays, buffer lengths and a full-duplex flag. A one-cycle start pulse launches the check, and the block answers with a one-byte completion code and a one-cycle done pulse.

The check is pipelined over two register stages. A new request may therefore be started on every cycle, and each request receives its own done pulse two cycles later. The completion code stays on the output until the next done pulse. A zero in a capability limit means one of two things, depending on the field. For word width and clock rate, zero means no limit. For the four delays, zero means the feature is absent.

Top module: `spi_req_check`

## Requirements
- R1: A lane count (`tx_lanes_i`, `rx_lanes_i`) of 0 or 1 selects one lane, 2 selects two lanes, 4 selects four and 8 selects eight. Any other value gives code 1 (parameter error).
- R2: One lane is always accepted. In each capability lane mask, bit 0 enables two lanes, bit 1 enables four and bit 2 enables eight. The transmit mask applies only to the transmit count and the receive mask only to the receive count. A request for a disabled width gives code 1.
- R3: Request mode bit 0 is clock phase and bit 1 is clock polarity. Capability mode bits [1:0] govern phase and bits [3:2] govern polarity: 00 allows either value, 01 allows only 0 and 10 allows only 1. A disallowed value gives code 1.
- R4: A capability phase pair or polarity pair of 11 is malformed. It gives code 2 (transfer error), and this code takes precedence over any parameter error.
- R5: Request mode bit 2 asks for an active-high select, bit 3 for LSB-first and bit 4 for loopback. Each of these is allowed only if capability mode bit 4, 5 or 6 respectively is set. Any set request mode bit 31..5 is a parameter error (code 1).
- R6: The chip-select index must be below `cap_cs_num_i`. A nonzero `cs_chg_i` requires `cap_cs_chg_i`=1. A violation of either rule gives code 1.
- R7: A zero word-width mask allows any width. When the mask is nonzero, the width must lie between 1 and 32 and mask bit (width−1) must be set; otherwise the code is 1.
- R8: A zero maximum clock rate allows any rate. When the maximum is nonzero, a requested rate above it gives code 1.
- R9: Each of the word, setup, hold and inactive delays must not exceed its maximum. A maximum of 0 therefore rejects any nonzero request (code 1).
- R10: In a full-duplex request, unequal transmit and receive lengths give code 1. In a half-duplex request the lengths are ignored.
- R11: A request that violates no rule gives code 0. `done_o` pulses for exactly one cycle, two clock edges after the edge that samples `start_i`. `result_o` changes only when `done_o` rises and holds its value between done pulses.
- R12: While `rst_ni` is low, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; request fields are sampled on this cycle |
| cs_idx_i | input | 8 | Chip-select index |
| bpw_i | input | 8 | Bits per word |
| cs_chg_i | input | 8 | Toggle chip select between transfers (nonzero = yes) |
| tx_lanes_i | input | 8 | Transmit lane count |
| rx_lanes_i | input | 8 | Receive lane count |
| mode_i | input | 32 | Request mode word |
| freq_i | input | 32 | Requested clock rate |
| dly_word_i | input | 32 | Requested inter-word delay |
| dly_setup_i | input | 32 | Requested delay after select asserted |
| dly_hold_i | input | 32 | Requested delay before select released |
| dly_inact_i | input | 32 | Requested delay while select released |
| tx_len_i | input | 16 | Transmit buffer length |
| rx_len_i | input | 16 | Receive buffer length |
| duplex_i | input | 1 | Full-duplex request |
| cap_cs_num_i | input | 8 | Number of chip selects |
| cap_cs_chg_i | input | 1 | Chip-select toggling supported |
| cap_tx_lanes_i | input | 3 | Transmit lane-support mask |
| cap_rx_lanes_i | input | 3 | Receive lane-support mask |
| cap_bpw_mask_i | input | 32 | Supported word widths, bit n = width n+1 |
| cap_mode_i | input | 7 | Mode-support word |
| cap_freq_max_i | input | 32 | Maximum clock rate, 0 = unlimited |
| cap_dly_word_i | input | 32 | Maximum inter-word delay |
| cap_dly_setup_i | input | 32 | Maximum setup delay |
| cap_dly_hold_i | input | 32 | Maximum hold delay |
| cap_dly_inact_i | input | 32 | Maximum inactive delay |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Completion code: 0 OK, 1 parameter error, 2 transfer error |

## Verification
The bench builds the block with its default parameters: an 8-bit select, word-width and lane field, a 32-entry word-width mask and 16-bit lengths. With these values the word width can be driven both below 1 and above 32, which reaches the out-of-range path of the mask lookup. The full 32-bit delay and rate fields allow maximum-equal and maximum-plus-one boundaries to be driven directly. Random requests start on consecutive cycles in some runs, which exercises the pipelined two-cycle latency.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
  typedef enum logic [7:0] {
    RES_OK      = 8'd0,
    RES_PARAM   = 8'd1,
    RES_XFER    = 8'd2
  } res_code_e;

  // request mode bit positions
  localparam int unsigned MB_PHASE = 0;
  localparam int unsigned MB_POL   = 1;
  localparam int unsigned MB_CSHI  = 2;
  localparam int unsigned MB_LSB   = 3;
  localparam int unsigned MB_LOOP  = 4;
  localparam int unsigned MB_USED  = 5;

  // capability mode bit positions
  localparam int unsigned CB_PHASE = 0;
  localparam int unsigned CB_POL   = 2;
  localparam int unsigned CB_CSHI  = 4;
  localparam int unsigned CB_LSB   = 5;
  localparam int unsigned CB_LOOP  = 6;
  localparam int unsigned CAP_MODE_W = 7;
endpackage

// File: rtl/spi_lane_check.sv
module spi_lane_check #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lanes_i,
  input  logic [2:0]   cap_i,
  output logic         err_o
);
  always_comb begin
    unique case (lanes_i)
      W'(0), W'(1): err_o = 1'b0;
      W'(2):        err_o = ~cap_i[0];
      W'(4):        err_o = ~cap_i[1];
      W'(8):        err_o = ~cap_i[2];
      default:      err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_limit_check.sv
module spi_limit_check #(
  parameter int unsigned W = 32,
  parameter bit ZERO_UNLIMITED = 1'b0
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] max_i,
  output logic         err_o
);
  generate
    if (ZERO_UNLIMITED) begin : g_unl
      assign err_o = (max_i != '0) && (req_i > max_i);
    end else begin : g_lim
      // max of zero rejects any nonzero request
      assign err_o = req_i > max_i;
    end
  endgenerate
endmodule

// File: rtl/spi_mode_check.sv
module spi_mode_check
  import spi_req_pkg::*;
(
  input  logic [31:0]           mode_i,
  input  logic [CAP_MODE_W-1:0] cap_i,
  output logic                  perr_o,
  output logic                  cap_bad_o
);
  function automatic logic pair_err(input logic sel, input logic [1:0] cap);
    unique case (cap)
      2'b00:   pair_err = 1'b0;
      2'b01:   pair_err = sel;
      2'b10:   pair_err = ~sel;
      default: pair_err = 1'b0;
    endcase
  endfunction

  logic [1:0] ph_cap, pol_cap;
  assign ph_cap  = cap_i[CB_PHASE+:2];
  assign pol_cap = cap_i[CB_POL+:2];

  assign cap_bad_o = (&ph_cap) | (&pol_cap);

  assign perr_o = pair_err(mode_i[MB_PHASE], ph_cap)
                | pair_err(mode_i[MB_POL], pol_cap)
                | (mode_i[MB_CSHI] & ~cap_i[CB_CSHI])
                | (mode_i[MB_LSB]  & ~cap_i[CB_LSB])
                | (mode_i[MB_LOOP] & ~cap_i[CB_LOOP])
                | (|mode_i[31:MB_USED]);
endmodule

// File: rtl/spi_req_check.sv
module spi_req_check
  import spi_req_pkg::*;
#(
  parameter int unsigned FLD_W   = 8,
  parameter int unsigned VAL_W   = 32,
  parameter int unsigned BPW_MAX = 32,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned N_DLY   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FLD_W-1:0]      cs_idx_i,
  input  logic [FLD_W-1:0]      bpw_i,
  input  logic [FLD_W-1:0]      cs_chg_i,
  input  logic [FLD_W-1:0]      tx_lanes_i,
  input  logic [FLD_W-1:0]      rx_lanes_i,
  input  logic [31:0]           mode_i,
  input  logic [VAL_W-1:0]      freq_i,
  input  logic [VAL_W-1:0]      dly_word_i,
  input  logic [VAL_W-1:0]      dly_setup_i,
  input  logic [VAL_W-1:0]      dly_hold_i,
  input  logic [VAL_W-1:0]      dly_inact_i,
  input  logic [LEN_W-1:0]      tx_len_i,
  input  logic [LEN_W-1:0]      rx_len_i,
  input  logic                  duplex_i,
  input  logic [FLD_W-1:0]      cap_cs_num_i,
  input  logic                  cap_cs_chg_i,
  input  logic [2:0]            cap_tx_lanes_i,
  input  logic [2:0]            cap_rx_lanes_i,
  input  logic [BPW_MAX-1:0]    cap_bpw_mask_i,
  input  logic [CAP_MODE_W-1:0] cap_mode_i,
  input  logic [VAL_W-1:0]      cap_freq_max_i,
  input  logic [VAL_W-1:0]      cap_dly_word_i,
  input  logic [VAL_W-1:0]      cap_dly_setup_i,
  input  logic [VAL_W-1:0]      cap_dly_hold_i,
  input  logic [VAL_W-1:0]      cap_dly_inact_i,
  output logic                  done_o,
  output logic [7:0]            result_o
);
  localparam int unsigned IDX_W = (BPW_MAX > 1) ? $clog2(BPW_MAX) : 1;
  localparam logic [FLD_W-1:0] BPW_TOP = FLD_W'(BPW_MAX);

  logic tx_lane_err, rx_lane_err, mode_err, cap_bad, freq_err;
  logic bpw_err, cs_err, len_err;
  logic [N_DLY-1:0] dly_err;
  logic [VAL_W-1:0] dly_req [N_DLY];
  logic [VAL_W-1:0] dly_max [N_DLY];

  spi_lane_check #(.W(FLD_W)) u_tx_lane (
    .lanes_i(tx_lanes_i), .cap_i(cap_tx_lanes_i), .err_o(tx_lane_err));
  spi_lane_check #(.W(FLD_W)) u_rx_lane (
    .lanes_i(rx_lanes_i), .cap_i(cap_rx_lanes_i), .err_o(rx_lane_err));

  spi_mode_check u_mode (
    .mode_i(mode_i), .cap_i(cap_mode_i), .perr_o(mode_err), .cap_bad_o(cap_bad));

  spi_limit_check #(.W(VAL_W), .ZERO_UNLIMITED(1'b1)) u_freq (
    .req_i(freq_i), .max_i(cap_freq_max_i), .err_o(freq_err));

  assign dly_req[0] = dly_word_i;
  assign dly_req[1] = dly_setup_i;
  assign dly_req[2] = dly_hold_i;
  assign dly_req[3] = dly_inact_i;
  assign dly_max[0] = cap_dly_word_i;
  assign dly_max[1] = cap_dly_setup_i;
  assign dly_max[2] = cap_dly_hold_i;
  assign dly_max[3] = cap_dly_inact_i;

  generate
    for (genvar i = 0; i < N_DLY; i++) begin : g_dly
      spi_limit_check #(.W(VAL_W), .ZERO_UNLIMITED(1'b0)) u_dly (
        .req_i(dly_req[i]), .max_i(dly_max[i]), .err_o(dly_err[i]));
    end
  endgenerate

  // word width: mask bit (bpw-1), only when mask restricts
  logic [FLD_W-1:0] bpw_m1;
  logic             bpw_in_rng;
  assign bpw_m1     = bpw_i - FLD_W'(1);
  assign bpw_in_rng = (bpw_i != '0) && (bpw_i <= BPW_TOP);
  assign bpw_err    = (cap_bpw_mask_i != '0) &&
                      !(bpw_in_rng && cap_bpw_mask_i[bpw_m1[IDX_W-1:0]]);

  assign cs_err  = (cs_idx_i >= cap_cs_num_i) | ((cs_chg_i != '0) & ~cap_cs_chg_i);
  assign len_err = duplex_i & (tx_len_i != rx_len_i);

  logic perr_c;
  assign perr_c = tx_lane_err | rx_lane_err | mode_err | freq_err | (|dly_err)
                | bpw_err | cs_err | len_err;

  // stage 1: error flags
  logic s1_vld, s1_perr, s1_cap_bad;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld     <= 1'b0;
      s1_perr    <= 1'b0;
      s1_cap_bad <= 1'b0;
    end else begin
      s1_vld <= start_i;
      if (start_i) begin
        s1_perr    <= perr_c;
        s1_cap_bad <= cap_bad;
      end
    end
  end

  // stage 2: held completion code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= RES_OK;
    end else begin
      done_o <= s1_vld;
      if (s1_vld) begin
        result_o <= s1_cap_bad ? RES_XFER : (s1_perr ? RES_PARAM : RES_OK);
      end
    end
  end
endmodule

// File: rtl/spi_req_check_sva.sv
module spi_req_check_sva #(
  parameter int unsigned FLD_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [FLD_W-1:0] cs_idx_i,
  input logic [FLD_W-1:0] cap_cs_num_i,
  input logic [6:0]       cap_mode_i,
  input logic             done_o,
  input logic [7:0]       result_o
);
  // R11: latency from start to done
  a_r11_start_to_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 done_o);
  a_r11_done_has_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R4: malformed capability pair yields transfer error
  a_r4_cap_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ((&$past(cap_mode_i[1:0], 2)) || (&$past(cap_mode_i[3:2], 2))))
      |-> result_o == 8'd2);
  // R6: select index out of range is never OK
  a_r6_cs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(cs_idx_i, 2) >= $past(cap_cs_num_i, 2))) |-> result_o != 8'd0);
  // R12: reset state
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r12_reset: assert (!done_o && result_o == 8'd0);
    end
  end
endmodule

bind spi_req_check spi_req_check_sva #(.FLD_W(FLD_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .cs_idx_i(cs_idx_i), .cap_cs_num_i(cap_cs_num_i), .cap_mode_i(cap_mode_i),
  .done_o(done_o), .result_o(result_o));

// File: tb/spi_req_check_tb.sv
module spi_req_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0;
  logic [7:0] cs_idx, bpw, cs_chg, tx_l, rx_l;
  logic [31:0] mode, freq, d_w, d_s, d_h, d_i;
  logic [15:0] tx_len, rx_len;
  logic duplex;
  logic [7:0] c_csn;
  logic c_cschg;
  logic [2:0] c_txl, c_rxl;
  logic [31:0] c_bpw;
  logic [6:0] c_mode;
  logic [31:0] c_fmax, c_dw, c_ds, c_dh, c_di;
  logic done;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;

  spi_req_check dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cs_idx_i(cs_idx), .bpw_i(bpw), .cs_chg_i(cs_chg), .tx_lanes_i(tx_l), .rx_lanes_i(rx_l),
    .mode_i(mode), .freq_i(freq), .dly_word_i(d_w), .dly_setup_i(d_s),
    .dly_hold_i(d_h), .dly_inact_i(d_i), .tx_len_i(tx_len), .rx_len_i(rx_len),
    .duplex_i(duplex), .cap_cs_num_i(c_csn), .cap_cs_chg_i(c_cschg),
    .cap_tx_lanes_i(c_txl), .cap_rx_lanes_i(c_rxl), .cap_bpw_mask_i(c_bpw),
    .cap_mode_i(c_mode), .cap_freq_max_i(c_fmax), .cap_dly_word_i(c_dw),
    .cap_dly_setup_i(c_ds), .cap_dly_hold_i(c_dh), .cap_dly_inact_i(c_di),
    .done_o(done), .result_o(result));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic lane_ok(input logic [7:0] v, input logic [2:0] m);
    case (v)
      8'd0, 8'd1: return 1'b1;
      8'd2: return m[0];
      8'd4: return m[1];
      8'd8: return m[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic pair_ok(input logic s, input logic [1:0] c);
    if (c == 2'b00) return 1'b1;
    if (c == 2'b01) return s == 1'b0;
    return s == 1'b1;
  endfunction

  function automatic logic [7:0] model();
    logic ok;
    if (c_mode[1:0] == 2'b11 || c_mode[3:2] == 2'b11) return 8'd2;
    ok = lane_ok(tx_l, c_txl) && lane_ok(rx_l, c_rxl);
    ok = ok && pair_ok(mode[0], c_mode[1:0]) && pair_ok(mode[1], c_mode[3:2]);
    ok = ok && !(mode[2] && !c_mode[4]) && !(mode[3] && !c_mode[5]) && !(mode[4] && !c_mode[6]);
    ok = ok && (mode[31:5] == 0);
    ok = ok && (cs_idx < c_csn) && !(cs_chg != 0 && !c_cschg);
    if (c_bpw != 0) ok = ok && bpw >= 1 && bpw <= 32 && c_bpw[bpw - 8'd1];
    if (c_fmax != 0) ok = ok && freq <= c_fmax;
    ok = ok && d_w <= c_dw && d_s <= c_ds && d_h <= c_dh && d_i <= c_di;
    if (duplex) ok = ok && tx_len == rx_len;
    return ok ? 8'd0 : 8'd1;
  endfunction

  task automatic baseline();
    cs_idx = 0; bpw = 8; cs_chg = 0; tx_l = 1; rx_l = 1; mode = 0; freq = 100;
    d_w = 0; d_s = 0; d_h = 0; d_i = 0; tx_len = 4; rx_len = 4; duplex = 0;
    c_csn = 4; c_cschg = 1; c_txl = 3'b111; c_rxl = 3'b111; c_bpw = 0;
    c_mode = 7'h70; c_fmax = 0; c_dw = 50; c_ds = 50; c_dh = 50; c_di = 50;
  endtask

  // inputs driven at negedge; done seen after second posedge
  task automatic run(input string req, input logic [7:0] exp);
    logic [7:0] prev;
    prev = result;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 no early done", {31'd0, done}, 32'd0);
    chk("R11 result held", {24'd0, result}, {24'd0, prev});
    @(negedge clk);
    chk("R11 done pulse", {31'd0, done}, 32'd1);
    chk(req, {24'd0, result}, {24'd0, exp});
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 32'd0);
    chk("R11 hold after done", {24'd0, result}, {24'd0, exp});
  endtask

  function automatic logic [7:0] rnd_lane();
    case ($urandom % 7)
      0: return 8'd0; 1: return 8'd1; 2: return 8'd2; 3: return 8'd4;
      4: return 8'd8; 5: return 8'd3; default: return 8'($urandom);
    endcase
  endfunction

  task automatic randomize_req();
    c_csn = 8'($urandom % 8); cs_idx = 8'($urandom % 8);
    cs_chg = ($urandom % 4 == 0) ? 8'd1 : 8'd0; c_cschg = 1'($urandom);
    tx_l = rnd_lane(); rx_l = rnd_lane();
    c_txl = 3'($urandom); c_rxl = 3'($urandom);
    c_mode = 7'($urandom);
    if ($urandom % 4 != 0) begin
      if (c_mode[1:0] == 2'b11) c_mode[1:0] = 2'b00;
      if (c_mode[3:2] == 2'b11) c_mode[3:2] = 2'b00;
    end
    mode = 32'($urandom % 32);
    if ($urandom % 16 == 0) mode[5 + $urandom % 27] = 1'b1;
    bpw = 8'($urandom % 36);
    c_bpw = ($urandom % 2 != 0) ? 32'd0 : $urandom;
    freq = $urandom % 1000; c_fmax = ($urandom % 3 == 0) ? 32'd0 : $urandom % 1000;
    d_w = ($urandom % 4 == 0) ? $urandom % 100 : 0; c_dw = ($urandom % 2 != 0) ? 0 : $urandom % 100;
    d_s = ($urandom % 4 == 0) ? $urandom % 100 : 0; c_ds = ($urandom % 2 != 0) ? 0 : $urandom % 100;
    d_h = ($urandom % 4 == 0) ? $urandom % 100 : 0; c_dh = ($urandom % 2 != 0) ? 0 : $urandom % 100;
    d_i = ($urandom % 4 == 0) ? $urandom % 100 : 0; c_di = ($urandom % 2 != 0) ? 0 : $urandom % 100;
    tx_len = 16'($urandom % 4); rx_len = 16'($urandom % 4); duplex = 1'($urandom);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    baseline();
    repeat (3) @(negedge clk);
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R12 reset result", {24'd0, result}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    baseline(); run("R11 legal request", 8'd0);
    // R1 lanes
    baseline(); tx_l = 0; rx_l = 8; run("R1 lanes 0 and 8", 8'd0);
    baseline(); tx_l = 3; run("R1 lane count 3", 8'd1);
    baseline(); rx_l = 16; run("R1 lane count 16", 8'd1);
    // R2 masks separate
    baseline(); c_txl = 3'b110; tx_l = 2; run("R2 tx dual disabled", 8'd1);
    baseline(); c_txl = 3'b000; rx_l = 4; run("R2 rx quad uses rx mask", 8'd0);
    baseline(); c_rxl = 3'b011; rx_l = 8; run("R2 rx octal disabled", 8'd1);
    // R3 pairs
    baseline(); c_mode[1:0] = 2'b01; mode[0] = 1; run("R3 phase only 0", 8'd1);
    baseline(); c_mode[3:2] = 2'b10; mode[1] = 1; run("R3 polarity only 1 ok", 8'd0);
    baseline(); c_mode[3:2] = 2'b10; run("R3 polarity 0 rejected", 8'd1);
    // R4
    baseline(); c_mode[1:0] = 2'b11; run("R4 malformed phase cap", 8'd2);
    baseline(); c_mode[3:2] = 2'b11; tx_l = 5; run("R4 precedence over param err", 8'd2);
    // R5
    baseline(); c_mode[4] = 0; mode[2] = 1; run("R5 active high unsupported", 8'd1);
    baseline(); mode[4:2] = 3'b111; run("R5 all optional modes supported", 8'd0);
    baseline(); mode[31] = 1; run("R5 reserved mode bit", 8'd1);
    // R6
    baseline(); cs_idx = 4; run("R6 cs index equals count", 8'd1);
    baseline(); cs_idx = 3; run("R6 cs index max", 8'd0);
    baseline(); c_cschg = 0; cs_chg = 1; run("R6 cs toggle unsupported", 8'd1);
    // R7
    baseline(); bpw = 0; run("R7 zero mask no limit", 8'd0);
    baseline(); c_bpw = 32'h8000_0080; bpw = 32; run("R7 top width allowed", 8'd0);
    baseline(); c_bpw = 32'h8000_0080; bpw = 9; run("R7 width not in mask", 8'd1);
    baseline(); c_bpw = 32'hFFFF_FFFF; bpw = 33; run("R7 width above 32", 8'd1);
    baseline(); c_bpw = 32'hFFFF_FFFF; bpw = 0; run("R7 width zero", 8'd1);
    // R8
    baseline(); c_fmax = 100; freq = 100; run("R8 rate at max", 8'd0);
    baseline(); c_fmax = 100; freq = 101; run("R8 rate above max", 8'd1);
    baseline(); freq = 32'hFFFF_FFFF; run("R8 zero max unlimited", 8'd0);
    // R9
    baseline(); d_h = 50; run("R9 hold at max", 8'd0);
    baseline(); d_s = 51; run("R9 setup above max", 8'd1);
    baseline(); c_di = 0; d_i = 1; run("R9 inactive unsupported", 8'd1);
    baseline(); c_dw = 0; run("R9 word delay unsupported zero req", 8'd0);
    // R10
    baseline(); duplex = 1; rx_len = 5; run("R10 duplex length mismatch", 8'd1);
    baseline(); duplex = 0; rx_len = 5; run("R10 half duplex ignores lengths", 8'd0);

    // random, mixing back-to-back starts
    for (int n = 0; n < 400; n++) begin
      logic [7:0] e;
      randomize_req();
      e = model();
      run("R1..R11 random", e);
    end
    for (int n = 0; n < 100; n++) begin
      logic [7:0] e0, e1;
      randomize_req(); e0 = model();
      start = 1'b1;
      @(negedge clk);
      randomize_req(); e1 = model();
      @(negedge clk);
      start = 1'b0;
      chk("R11 back-to-back first done", {31'd0, done}, 32'd1);
      chk("R11 back-to-back first code", {24'd0, result}, {24'd0, e0});
      @(negedge clk);
      chk("R11 back-to-back second done", {31'd0, done}, 32'd1);
      chk("R11 back-to-back second code", {24'd0, result}, {24'd0, e1});
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule